// File: doc/BRIEF.md
# Thirty-two pin GPIO bank with grouped interrupts

This block is one bank of general-purpose pins controlled through a small word-addressed register bus. Each pin can be driven from an output register or left as an input. An output pin can also be switched to blink, driven by a shared square wave whose half period is a parameter counted in clock cycles. Inputs pass through a two-flop synchronizer. A per-pin polarity bit can invert the synchronized value before software or the interrupt logic sees it.

Interrupt sensing works on the polarity-corrected input. In level mode that value is the cause of the interrupt. In edge mode a 0-to-1 change of that value sets a sticky cause bit, which software clears by writing zeros. Each pin's masked causes are merged into one of four interrupt lines, with eight adjacent pins per line. Software that wants an interrupt on both edges flips the polarity bit after each event.

Top module: `gpio_bank_irq`

## Requirements
- R1: Register offsets (byte address, word aligned): 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C polarity, 0x10 corrected input, 0x14 edge cause, 0x18 edge mask, 0x1C level mask. A write to 0x00, 0x04, 0x08, 0x0C, 0x18 or 0x1C stores the data, and a read returns the stored data. Any address with a bit at position 5 or above set reads zero, and a write to it changes nothing.
- R2: A direction bit of 1 makes the pin an input, so its enable `pad_oe` is 0. A direction bit of 0 makes it an output, so `pad_oe` is 1.
- R3: The input register at 0x10 reads the pad value, delayed by two clock edges, XORed with the polarity register. Writes to 0x10 are ignored.
- R4: A pin's level cause is its corrected input ANDed with its level mask bit.
- R5: A 0-to-1 transition of a pin's corrected input sets its edge cause bit on the next clock edge. A 1-to-0 transition does not set it. The bit then stays set until software clears it.
- R6: A write to 0x14 clears each cause bit written as 0 and leaves each bit written as 1 unchanged. If a set and a clear hit the same bit on the same edge, the bit ends up set.
- R7: `irq[g]` is the OR of the causes of pins 8g to 8g+7. A pin's cause is (corrected input AND level mask) OR (edge cause AND edge mask).
- R8: For an output pin whose blink bit is 1, `pad_out` follows a shared phase that starts at 0 and toggles every BLINK_HALF cycles. For a pin whose blink bit is 0, `pad_out` equals its output register bit.
- R9: After reset, direction is all ones, so every pin is an input. Output, blink, polarity, edge cause, edge mask and level mask are all zero.
- R10: A pin configured as an output still feeds its input register and its cause logic from the pad value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data for `addr` (combinational) |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables, 1 = drive |
| irq | output | NPINS/GRP | Grouped interrupt lines |

## Verification
Several scalar patterns set single pins in chosen groups. They show whether a cause lands on the right one of the four lines and whether the polarity bit flips a level cause. Rising edges and falling edges are applied to the same pin to separate true edge detection from simple level copying. A clear write is timed to land on the same edge as a new event, which shows whether set wins over clear. A wide pattern with mixed polarity, together with toggling an output-configured pin, checks that the input path ignores direction. A blinking pin placed next to a steady pin checks the phase period and that the two pins do not affect each other.

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NPINS      = 32,
  parameter int GRP        = 8,
  parameter int ADDR_W     = 8,
  parameter int BLINK_HALF = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS/GRP-1:0] irq
);
  localparam int NIRQ = NPINS / GRP;
  localparam int CW   = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [2:0] SEL_OUT = 3'd0, SEL_DIR = 3'd1, SEL_BLK = 3'd2, SEL_POL = 3'd3,
                         SEL_DIN = 3'd4, SEL_CAU = 3'd5, SEL_EMK = 3'd6, SEL_LMK = 3'd7;

  logic [NPINS-1:0] out_r, dir_r, blk_r, pol_r, cau_r, emk_r, lmk_r;
  logic [NPINS-1:0] sync1, sync2, din_q;
  logic [CW-1:0]    bcnt;
  logic             phase;

  logic [2:0]       sel;
  logic             in_range, wr_hit;
  logic [NPINS-1:0] din, rise, keep, pin_cause;

  assign sel      = addr[4:2];
  assign in_range = (addr >> 5) == '0;
  assign wr_hit   = wr_en && in_range;
  assign din      = sync2 ^ pol_r;
  assign rise     = din & ~din_q;
  assign keep     = (wr_hit && sel == SEL_CAU) ? wdata : '1;
  assign pin_cause = (din & lmk_r) | (cau_r & emk_r);

  assign pad_oe  = ~dir_r;
  assign pad_out = (out_r & ~blk_r) | ({NPINS{phase}} & blk_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      din_q <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      din_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_r <= '0;
      dir_r <= '1;
      blk_r <= '0;
      pol_r <= '0;
      emk_r <= '0;
      lmk_r <= '0;
    end else if (wr_hit) begin
      case (sel)
        SEL_OUT: out_r <= wdata;
        SEL_DIR: dir_r <= wdata;
        SEL_BLK: blk_r <= wdata;
        SEL_POL: pol_r <= wdata;
        SEL_EMK: emk_r <= wdata;
        SEL_LMK: lmk_r <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cau_r <= '0;
    else        cau_r <= (cau_r & keep) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt  <= '0;
      phase <= 1'b0;
    end else if (bcnt == CW'(BLINK_HALF - 1)) begin
      bcnt  <= '0;
      phase <= ~phase;
    end else begin
      bcnt <= bcnt + 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_range) begin
      case (sel)
        SEL_OUT: rdata = out_r;
        SEL_DIR: rdata = dir_r;
        SEL_BLK: rdata = blk_r;
        SEL_POL: rdata = pol_r;
        SEL_DIN: rdata = din;
        SEL_CAU: rdata = cau_r;
        SEL_EMK: rdata = emk_r;
        SEL_LMK: rdata = lmk_r;
        default: rdata = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NIRQ; g++) begin : g_irq
    assign irq[g] = |pin_cause[g*GRP +: GRP];
  end

  a_r6_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && sel == SEL_CAU) |=> ((cau_r & $past(cau_r)) == $past(cau_r)));

  a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((cau_r & $past(rise)) == $past(rise)));

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lmk_r == '0 && emk_r == '0) |-> (irq == '0));

  a_r8_steady_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ out_r) & ~blk_r) == '0);

  a_r8_phase_period: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt != '0) |-> $stable(phase));
endmodule

// File: tb/gpio_bank_irq_tb_top.sv
module gpio_bank_irq_tb_top;
  localparam int BH = 5;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, pad_in = 0;
  logic [31:0] rdata, pad_out, pad_oe;
  logic [3:0]  irq;
  int errors = 0, checks = 0;

  gpio_bank_irq #(.NPINS(32), .GRP(8), .ADDR_W(8), .BLINK_HALF(BH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  always #10 clk = ~clk;

  // behavioural reference state
  logic [31:0] m_out, m_dir, m_blk, m_pol, m_ec, m_em, m_lm, m_s1, m_s2, m_prev;
  logic [31:0] q_d, q_r, q_k;
  int m_cnt; logic m_ph;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_dir = '1; m_blk = 0; m_pol = 0; m_ec = 0; m_em = 0; m_lm = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_cnt = 0; m_ph = 0;
    end else begin
      q_d = m_s2 ^ m_pol;
      q_r = q_d & ~m_prev;
      q_k = (wr_en && addr == 8'h14) ? wdata : '1;
      m_ec = (m_ec & q_k) | q_r;
      m_prev = q_d; m_s2 = m_s1; m_s1 = pad_in;
      if (wr_en) case (addr)
        8'h00: m_out = wdata; 8'h04: m_dir = wdata; 8'h08: m_blk = wdata;
        8'h0C: m_pol = wdata; 8'h18: m_em = wdata; 8'h1C: m_lm = wdata;
        default: ;
      endcase
      if (m_cnt == BH - 1) begin m_cnt = 0; m_ph = ~m_ph; end else m_cnt++;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_out; 8'h04: return m_dir; 8'h08: return m_blk; 8'h0C: return m_pol;
      8'h10: return m_s2 ^ m_pol; 8'h14: return m_ec; 8'h18: return m_em; 8'h1C: return m_lm;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [31:0] c; logic [3:0] r;
    c = ((m_s2 ^ m_pol) & m_lm) | (m_ec & m_em);
    for (int g = 0; g < 4; g++) r[g] = |c[g*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk("R8 pad_out", pad_out, (m_out & ~m_blk) | ({32{m_ph}} & m_blk));
      chk("R2 pad_oe", pad_oe, ~m_dir);
      chk("R7 irq", {28'h0, irq}, {28'h0, exp_irq()});
      chk("R1 rdata", rdata, exp_rd(addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #2;
    chk(tag, rdata, exp);
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int tog; logic last;
    waitc(3); rst_n = 1;
    // R9 reset state
    rd("R9 dir", 8'h04, 32'hFFFF_FFFF);
    rd("R9 out", 8'h00, 0); rd("R9 blink", 8'h08, 0); rd("R9 pol", 8'h0C, 0);
    rd("R9 cause", 8'h14, 0); rd("R9 emask", 8'h18, 0); rd("R9 lmask", 8'h1C, 0);
    chk("R9 pad_oe", pad_oe, 0); chk("R9 irq", {28'h0, irq}, 0);
    // R1 register map
    wr(8'h00, 32'hA5A5_0F0F); rd("R1 out", 8'h00, 32'hA5A5_0F0F);
    wr(8'h04, 32'hFFFF_0000); rd("R1 dir", 8'h04, 32'hFFFF_0000);
    chk("R2 oe", pad_oe, 32'h0000_FFFF);
    wr(8'h0C, 32'h00FF_00FF); rd("R1 pol", 8'h0C, 32'h00FF_00FF);
    rd("R1 undefined 0x20", 8'h20, 0); rd("R1 undefined 0x40", 8'h40, 0);
    wr(8'h20, 32'hFFFF_FFFF); rd("R1 write to undefined", 8'h00, 32'hA5A5_0F0F);
    // R3 polarity corrected input, write ignored
    pad_in = 32'h1234_5678; waitc(3);
    rd("R3 data-in", 8'h10, 32'h1234_5678 ^ 32'h00FF_00FF);
    wr(8'h10, 32'h0); rd("R3 data-in write ignored", 8'h10, 32'h1234_5678 ^ 32'h00FF_00FF);
    // R10 output pin still feeds input path
    pad_in = 32'h0000_0001; waitc(3);
    rd("R10 out pin input", 8'h10, 32'h0000_0001 ^ 32'h00FF_00FF);
    wr(8'h14, 0); wr(8'h0C, 0); pad_in = 0; waitc(3); wr(8'h14, 0);
    rd("R6 cleared", 8'h14, 0);
    // R4 level, polarity flips it
    wr(8'h1C, 32'h0000_0010); pad_in = 32'h10; waitc(3);
    chk("R4 level on", {28'h0, irq}, 4'b0001);
    wr(8'h0C, 32'h10); waitc(1);
    chk("R4 level inverted off", {28'h0, irq}, 0);
    wr(8'h0C, 0); wr(8'h1C, 0); pad_in = 0; waitc(3); wr(8'h14, 0);
    // R5 edge on pin 9
    pad_in = 32'h200; waitc(3);
    rd("R5 rise sets", 8'h14, 32'h200);
    wr(8'h18, 32'h200); chk("R7 edge to line1", {28'h0, irq}, 4'b0010);
    wr(8'h14, 32'hFFFF_FFFF); rd("R6 write one keeps", 8'h14, 32'h200);
    wr(8'h14, ~32'h200); rd("R6 write zero clears", 8'h14, 0);
    pad_in = 0; waitc(3);
    rd("R5 fall no set", 8'h14, 0);
    // R6 set wins over same-edge clear, pin 17
    @(negedge clk); pad_in = 32'h2_0000;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1; addr = 8'h14; wdata = 0;
    @(negedge clk); wr_en = 0;
    rd("R6 set beats clear", 8'h14, 32'h2_0000);
    wr(8'h14, 0); pad_in = 0; wr(8'h18, 0); waitc(3);
    // R7 pin 31 only on line 3
    wr(8'h1C, 32'h8000_0000); pad_in = 32'h8000_0000; waitc(3);
    chk("R7 pin31 line3", {28'h0, irq}, 4'b1000);
    wr(8'h1C, 0); pad_in = 0; waitc(3); wr(8'h14, 0);
    // R8 blink pin 2 output, pin 3 steady
    wr(8'h04, 32'hFFFF_FFF3); wr(8'h00, 32'h8); wr(8'h08, 32'h4);
    tog = 0; last = pad_out[2];
    for (int i = 0; i < 4 * BH; i++) begin
      @(negedge clk);
      if (pad_out[2] !== last) tog++;
      last = pad_out[2];
      if (pad_out[3] !== 1'b1) chk("R8 steady pin", {31'h0, pad_out[3]}, 1);
    end
    chk("R8 blink toggles", tog, 4);
    wr(8'h08, 0); waitc(1);
    chk("R8 blink off drives out", pad_out & 32'hC, 32'h8);
    waitc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule